// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is an SPI master that software controls through a six-byte register window. One byte configures the serial link: idle level of the serial clock, which clock edge samples incoming data, how long a frame is, and how the chip selects are driven. One read-only byte reports whether a transfer is in progress. Four bytes hold a 32-bit data word. The word is sent out most significant bit first and is then overwritten with the bits received on the input line.

A frame starts when software writes the most significant data byte. The frame carries 8, 16, 24 or 32 bits, taken from the top of the data word. In automatic select mode the block asserts the chosen active-low select for the frame. It leaves at least half a serial clock period before the first clock edge and after the last one. In manual mode the select lines mirror the encoded select field at all times, and software handles the framing. The serial clock is derived from the system clock by a parameterised half-period divider.

Top module: `spi_regmaster`

## Requirements
- R1: Register offsets are 0 for control, 1 for status and 2 to 5 for data bytes 0 to 3. Offsets 6 and 7 read as zero. Every register resets to zero.
- R2: The control byte holds the clock idle level in bit 7, the sample-edge select in bit 6, the length code in bits 5:4, manual mode in bit 3 and the select code in bits 2:0. Outside a frame, SCLK sits at the level of bit 7.
- R3: When bit 6 is 0, MISO is sampled on rising SCLK edges. When bit 6 is 1, it is sampled on falling edges. MOSI changes only on the other edge, and the first bit is valid before the first sampling edge.
- R4: Length codes 0, 1, 2 and 3 give frames of 8, 16, 24 and 32 bits, which is 2N SCLK edges. Bits go out MSB first, starting from data bit 31. After the frame, the received bits replace the top N bits of the data word, and the lower bits are left unchanged.
- R5: In automatic mode (bit 3 = 0), select code k from 1 to 4 drives ssN[k-1] low for the frame only. The select falls at least one half period before the first edge and rises at least one half period after the last edge. At most one select is ever low.
- R6: In manual mode, ssN[k-1] is low exactly while the select code is k (1 to 4). It does not change during a transfer.
- R7: With select code 0, 5, 6 or 7, a write to data byte 3 starts no frame and makes no SCLK edge. The busy flag (status bit 0) is then high for exactly one cycle.
- R8: For a valid code, the busy flag is high for HALF_DIV*(2N+2) cycles, starting at the cycle after the triggering write. It falls in the same cycle that the received data appears.
- R9: While busy is high, writes to the control and data registers are ignored. This includes a second write to data byte 3, which starts nothing.
- R10: Consecutive SCLK edges are HALF_DIV system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Active-low slave selects |

## Verification
The assertions assume that the register port sees at most one write per cycle and that the control byte can change only through a write, which the block itself blocks while busy. They also assume MISO is settled at each system clock edge on which SCLK moves to its sampling level. The bench's slave model respects this: it changes MISO only one nanosecond after the falling system clock edge that follows a sampling edge. It drives register writes only on falling clock edges, and it reconfigures the control byte only while the block is idle, apart from the dedicated busy-write test.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;
  localparam int LEN_W      = 2;
  localparam int WORD_BYTES = 2 ** LEN_W;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int NUM_SS     = 4;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_STAT   = 1;
  localparam int OFS_DATA0  = 2;

  // Control byte, MSB first: idle level, sample edge, length, manual, select
  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [LEN_W-1:0] lenCode;
    logic             manual;
    logic [2:0]       ssCode;
  } spiCtrl_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftTx;
    logic sampleRx;
    logic finish;
  } spiStrobe_t;
endpackage

// File: rtl/spi_regmaster_dp.sv
module spi_regmaster_dp
  import spi_regmaster_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       busy,
  input  spiStrobe_t strobe,
  input  logic       miso,
  output logic [7:0] regRdData,
  output spiCtrl_t   ctrl,
  output logic       startReq,
  output logic       mosi
);
  localparam logic [2:0] CTRL_A = 3'(OFS_CTRL);
  localparam logic [2:0] STAT_A = 3'(OFS_STAT);
  localparam logic [2:0] LAST_A = 3'(OFS_DATA0 + WORD_BYTES - 1);

  logic [WORD_W-1:0] dataQ, dataNext, txQ, rxQ, topMask, rxAligned;
  logic [6:0]        frameBits;
  logic              wrOk;

  assign wrOk      = regWrEn && !busy;
  assign startReq  = wrOk && (regAddr == LAST_A);
  assign frameBits = 7'({ctrl.lenCode, 3'b000}) + 7'd8;
  assign topMask   = ~({WORD_W{1'b1}} >> frameBits);
  assign rxAligned = rxQ << (7'(WORD_W) - frameBits);
  assign mosi      = txQ[WORD_W-1];

  always_comb begin
    dataNext = dataQ;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (wrOk && regAddr == 3'(OFS_DATA0 + b)) dataNext[b*8 +: 8] = regWrData;
    end
    if (strobe.finish) dataNext = (dataQ & ~topMask) | (rxAligned & topMask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ <= '0;
      txQ   <= '0;
      rxQ   <= '0;
      ctrl  <= '0;
    end else begin
      dataQ <= dataNext;
      if (wrOk && regAddr == CTRL_A) ctrl <= spiCtrl_t'(regWrData);
      if (startReq) txQ <= {regWrData, dataQ[WORD_W-9:0]};
      else if (strobe.shiftTx) txQ <= txQ << 1;
      if (strobe.sampleRx) rxQ <= {rxQ[WORD_W-2:0], miso};
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_A) regRdData = ctrl;
    if (regAddr == STAT_A) regRdData = {7'b0, busy};
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (regAddr == 3'(OFS_DATA0 + b)) regRdData = dataQ[b*8 +: 8];
    end
  end
endmodule

// File: rtl/spi_regmaster_ctrl.sv
module spi_regmaster_ctrl
  import spi_regmaster_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spiCtrl_t          ctrl,
  input  logic              startReq,
  output spiStrobe_t        strobe,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_SS-1:0] ssN
);
  localparam int         CNT_W  = $clog2(HALF_DIV + 1);
  localparam logic [2:0] SS_MAX = 3'(NUM_SS);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} state_t;

  state_t     state;
  logic [CNT_W-1:0] divCnt;
  logic [7:0] edgeCnt, edgeLast;
  logic [6:0] frameBits;
  logic       sclkQ, sampledAny, nullQ, tick, sampleEdge, codeValid, inFrame;

  assign codeValid  = (ctrl.ssCode != 3'd0) && (ctrl.ssCode <= SS_MAX);
  assign frameBits  = 7'({ctrl.lenCode, 3'b000}) + 7'd8;
  assign edgeLast   = {frameBits, 1'b0} - 8'd1;
  assign tick       = (divCnt == CNT_W'(HALF_DIV - 1));
  assign sampleEdge = (!sclkQ) ^ ctrl.cpha;  // next level high xor phase
  assign inFrame    = (state != ST_IDLE);

  assign strobe.sampleRx = (state == ST_XFER) && tick && sampleEdge;
  assign strobe.shiftTx  = (state == ST_XFER) && tick && !sampleEdge && sampledAny;
  assign strobe.finish   = (state == ST_TRAIL) && tick;

  assign busy = inFrame || nullQ;
  assign sclk = inFrame ? sclkQ : ctrl.cpol;

  for (genvar i = 0; i < NUM_SS; i++) begin : g_sel
    logic hit;
    assign hit    = (ctrl.ssCode == 3'(i + 1));
    assign ssN[i] = ctrl.manual ? !hit : !(hit && inFrame);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      edgeCnt    <= '0;
      sclkQ      <= 1'b0;
      sampledAny <= 1'b0;
      nullQ      <= 1'b0;
    end else begin
      nullQ <= startReq && !codeValid;
      if (state != ST_IDLE) divCnt <= tick ? '0 : divCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          divCnt <= '0;
          if (startReq && codeValid) begin
            state      <= ST_LEAD;
            edgeCnt    <= '0;
            sclkQ      <= ctrl.cpol;
            sampledAny <= 1'b0;
          end
        end
        ST_LEAD:  if (tick) state <= ST_XFER;
        ST_XFER: begin
          if (tick) begin
            sclkQ   <= ~sclkQ;
            edgeCnt <= edgeCnt + 8'd1;
            if (sampleEdge) sampledAny <= 1'b1;
            if (edgeCnt == edgeLast) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (tick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_regmaster_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic [3:0] ssN
);
  spiCtrl_t   ctrl;
  spiStrobe_t strobe;
  logic       busyQ, startReq;
  logic [7:0] ctrlQ;

  assign ctrlQ = ctrl;

  spi_regmaster_dp u_dp (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .busy(busyQ), .strobe(strobe), .miso(miso),
    .regRdData(regRdData), .ctrl(ctrl), .startReq(startReq), .mosi(mosi)
  );

  spi_regmaster_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .startReq(startReq),
    .strobe(strobe), .busy(busyQ), .sclk(sclk), .ssN(ssN)
  );
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sclk,
  input logic [3:0] ssN,
  input logic [7:0] ctrlQ
);
  logic badCode;
  assign badCode = (ctrlQ[2:0] == 3'd0) || (ctrlQ[2:0] > 3'd4);

  // R5
  auto_idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlQ[3] && !busy) |-> (ssN == 4'hF));

  // R5
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ssN));

  // R6
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlQ[3] && $stable(ctrlQ)) |-> $stable(ssN));

  // R9
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrlQ));

  // R2
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(ctrlQ)) |-> $stable(sclk));

  // R7
  null_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && badCode) |=> !busy);

  // R8
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !badCode) |=> busy);
endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busyQ), .sclk(sclk), .ssN(ssN), .ctrlQ(ctrlQ)
);

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;
  localparam int CLK_PERIOD = 10;
  localparam int HDIV       = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] regAddr = 3'd1;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sclk, mosi, miso = 1'b0;
  logic [3:0] ssN;

  int checkCnt = 0, failCnt = 0;

  spi_regmaster #(.HALF_DIV(HDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ssN(ssN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model and link monitor
  bit slaveOn = 0, slaveCpha = 0, ssMoved = 0, prevSclk = 0, prevSsAll = 1;
  int cyc = 0, edgeCnt = 0, firstEdge = 0, lastEdge = 0, ssFall = 0, ssRise = 0;
  int minGap = 0, busyCyc = 0, bitIdx = 0;
  logic [31:0] slaveTx = '0, rxSlave = '0;
  logic [3:0]  ssLowVal = 4'hF, ssManExp = 4'hF;

  always @(negedge clk) begin
    #1;
    cyc++;
    if (slaveOn) begin
      if (regAddr == 3'd1 && !regWrEn && regRdData[0]) busyCyc++;
      if (ssN != 4'hF && prevSsAll) ssFall = cyc;
      if (ssN == 4'hF && !prevSsAll) ssRise = cyc;
      if (ssN != 4'hF) ssLowVal = ssN;
      if (ssN != ssManExp) ssMoved = 1;
      if (sclk != prevSclk) begin
        edgeCnt++;
        if (edgeCnt == 1) firstEdge = cyc;
        else if (cyc - lastEdge < minGap) minGap = cyc - lastEdge;
        lastEdge = cyc;
        if (sclk ^ slaveCpha) begin
          rxSlave = {rxSlave[30:0], mosi};
          bitIdx++;
          if (bitIdx < 32) miso = slaveTx[31-bitIdx];
        end
      end
    end
    prevSclk  = sclk;
    prevSsAll = (ssN == 4'hF);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd1;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
    regAddr = 3'd1;
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      readReg(3'(2 + i), b);
      w[i*8 +: 8] = b;
    end
  endtask

  task automatic waitIdle();
    regAddr = 3'd1;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      #2;
      if (!regRdData[0]) break;
    end
  endtask

  task automatic armSlave(input bit cpha, input logic [31:0] tx, input logic [3:0] manExp);
    slaveCpha = cpha; slaveTx = tx; miso = tx[31]; bitIdx = 0; rxSlave = '0;
    edgeCnt = 0; busyCyc = 0; minGap = 1000; ssMoved = 0; ssLowVal = 4'hF;
    ssFall = 0; ssRise = 0; ssManExp = manExp;
    slaveOn = 1;
  endtask

  // full transfer with checks of R3, R4, R5/R6, R8, R10
  task automatic doXfer(input bit cpol, input bit cpha, input logic [1:0] len, input bit man,
                        input logic [2:0] code, input logic [31:0] mData, input logic [31:0] sData);
    int n;
    logic [31:0] mask, got, expW;
    logic [3:0] manExp;
    n = (int'(len) + 1) * 8;
    mask = ~(32'hFFFF_FFFF >> n);
    manExp = man ? ~(4'b0001 << (code - 3'd1)) : 4'hF;
    writeReg(3'd0, {cpol, cpha, len, man, code});
    for (int i = 0; i < 3; i++) writeReg(3'(2 + i), mData[i*8 +: 8]);
    armSlave(cpha, sData, manExp);
    writeReg(3'd5, mData[31:24]);
    waitIdle();
    slaveOn = 0;
    readWord(got);
    expW = (mData & ~mask) | (sData & mask);
    chk(got == expW, "R3/R4 received data", got, expW);
    chk(((rxSlave << (32 - n)) & mask) == (mData & mask), "R3/R4 MOSI msb first",
        (rxSlave << (32 - n)) & mask, mData & mask);
    chk(edgeCnt == 2*n, "R4 edge count", edgeCnt, 2*n);
    chk(busyCyc == HDIV*(2*n+2), "R8 busy length", busyCyc, HDIV*(2*n+2));
    chk(minGap == HDIV, "R10 half period", minGap, HDIV);
    chk(sclk == cpol, "R2 idle level after frame", sclk, cpol);
    if (man) begin
      chk(!ssMoved, "R6 select steady in manual", ssMoved, 0);
    end else begin
      chk(ssLowVal == ~(4'b0001 << (code - 3'd1)), "R5 chosen select", ssLowVal, ~(4'b0001 << (code - 3'd1)));
      chk(firstEdge - ssFall >= HDIV, "R5 lead time", firstEdge - ssFall, HDIV);
      chk(ssRise - lastEdge >= HDIV, "R5 trail time", ssRise - lastEdge, HDIV);
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      chk(v == 8'h00, "R1 reset value", v, 0);
    end
    chk(ssN == 4'hF, "R5 selects idle at reset", ssN, 4'hF);
    chk(sclk == 1'b0, "R2 clock low at reset", sclk, 0);
  endtask

  task automatic testMap();
    logic [7:0] v;
    writeReg(3'd2, 8'h11); writeReg(3'd3, 8'h22); writeReg(3'd4, 8'h33);
    readReg(3'd2, v); chk(v == 8'h11, "R1 data byte 0", v, 8'h11);
    readReg(3'd3, v); chk(v == 8'h22, "R1 data byte 1", v, 8'h22);
    readReg(3'd4, v); chk(v == 8'h33, "R1 data byte 2", v, 8'h33);
    writeReg(3'd0, 8'h80);
    readReg(3'd0, v); chk(v == 8'h80, "R1 control readback", v, 8'h80);
    chk(sclk == 1'b1, "R2 idle high", sclk, 1);
    writeReg(3'd0, 8'h00);
    chk(sclk == 1'b0, "R2 idle low", sclk, 0);
    readReg(3'd6, v); chk(v == 8'h00, "R1 unused offset", v, 0);
  endtask

  task automatic testNull(input logic [2:0] code, input bit man);
    logic [7:0] v;
    writeReg(3'd0, {4'b0000, man, code});
    armSlave(0, 32'h0, man ? 4'hF : 4'hF);
    writeReg(3'd5, 8'h5A);
    repeat (10) @(negedge clk);
    slaveOn = 0;
    chk(busyCyc == 1, "R7 busy single pulse", busyCyc, 1);
    chk(edgeCnt == 0, "R7 no clock edges", edgeCnt, 0);
    chk(ssLowVal == 4'hF, "R7 no select", ssLowVal, 4'hF);
    readReg(3'd5, v); chk(v == 8'h5A, "R7 byte stored", v, 8'h5A);
  endtask

  task automatic testManualStatic();
    writeReg(3'd0, 8'h0B);
    chk(ssN == 4'b1011, "R6 manual code 3", ssN, 4'b1011);
    writeReg(3'd0, 8'h0C);
    chk(ssN == 4'b0111, "R6 manual code 4", ssN, 4'b0111);
    writeReg(3'd0, 8'h0F);
    chk(ssN == 4'hF, "R6 manual code 7", ssN, 4'hF);
    writeReg(3'd0, 8'h08);
    chk(ssN == 4'hF, "R6 manual code 0", ssN, 4'hF);
  endtask

  task automatic testBusyWrites();
    logic [7:0] v;
    logic [31:0] got;
    writeReg(3'd0, 8'h32);  // 32-bit, auto, select 2
    for (int i = 0; i < 3; i++) writeReg(3'(2 + i), 8'hC0 + 8'(i));
    armSlave(0, 32'h1234_5678, 4'hF);
    writeReg(3'd5, 8'hC3);
    writeReg(3'd0, 8'hC9);
    writeReg(3'd5, 8'hEE);
    writeReg(3'd2, 8'hEE);
    waitIdle();
    slaveOn = 0;
    readReg(3'd0, v); chk(v == 8'h32, "R9 control kept", v, 8'h32);
    readWord(got); chk(got == 32'h1234_5678, "R9 data not overwritten", got, 32'h1234_5678);
    chk(edgeCnt == 64, "R9 no retrigger", edgeCnt, 64);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testMap();
    doXfer(0, 0, 2'd0, 0, 3'd1, 32'hA500_0000, 32'h3C00_0000);
    doXfer(0, 1, 2'd1, 0, 3'd2, 32'h8123_4567, 32'hF0E1_D2C3);
    doXfer(1, 0, 2'd2, 0, 3'd3, 32'h5A5A_5A5A, 32'h0F1E_2D3C);
    doXfer(1, 1, 2'd3, 0, 3'd4, 32'hDEAD_BEEF, 32'h1357_9BDF);
    doXfer(0, 0, 2'd3, 1, 3'd2, 32'h0123_4567, 32'hFEDC_BA98);
    testNull(3'd0, 0);
    testNull(3'd6, 0);
    testNull(3'd0, 1);
    testManualStatic();
    testBusyWrites();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule